// File: doc/BRIEF.md
# Multiprocessor Device Interrupt Router

This block collects interrupt events from up to 64 device lines into one shared request vector and forwards them to up to four processors. Each processor owns a 64-bit enable mask. From each mask the block derives a pending vector, which is the mask ANDed with the shared request vector. Each processor has one level interrupt output. That output stays high while its pending vector holds any set bit.

Devices raise and lower their lines with one-cycle set and clear pulses on a dedicated side interface. Software uses a simple 64-bit register port. Through it, software programs the masks and reads the masks, the pending vectors and the request vector. Registers are reached through two address maps. The direct map selects a register by the byte offset shifted right by six. The indexed window takes the processor number from offset bits [9:4]. Illegal accesses do not stop the block. They raise a sticky error flag, and an illegal read returns zero.

Top module: `irq_router`

## Requirements
- R1: After reset all masks, pending vectors and the request vector are zero, every `cpu_irq_o` bit is low and `bus_err_o` is low.
- R2: A `dev_set_i` bit ORs that line into the request vector and a `dev_clr_i` bit removes it. When both are given for one line in the same cycle, the set wins.
- R3: A clear pulse for a line whose request bit is already zero changes no state: the request vector, the pending vectors and the interrupt outputs all stay the same.
- R4: Each processor's pending vector equals its mask ANDed with the request vector. It follows a mask write and any request change in the same cycle the mask or request register updates.
- R5: `cpu_irq_o[c]` is high exactly when processor c's pending vector is non-zero. It changes on the clock edge that registers the causing write or device pulse.
- R6: Direct map: with offset bits 12 and 13 clear, register number = offset[11:6]. Numbers 0..3 are the masks of processors 0..3 (read/write), 8..11 are their pending vectors (read-only), and 16 is the request vector (read-only).
- R7: Indexed window: offset bit 12 set selects a mask, otherwise offset bit 13 set selects a pending vector. In both cases the processor number is offset[9:4].
- R8: Only `bus_size_i` = 8 (bytes) is legal. Any other size sets the error flag, changes no state, and a read of that kind returns zero.
- R9: A write to a pending vector or to the request vector sets the error flag and changes no state.
- R10: A register number not listed in R6, or a processor number of 4 or more, sets the error flag, and a read returns zero.
- R11: The error flag stays high once set, until reset.
- R12: Every read request yields `bus_rvalid_o` high for one cycle on the following clock edge, with the data on `bus_rdata_o`. Writes never raise `bus_rvalid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_set_i | input | 64 | One-cycle set pulses, one per device line |
| dev_clr_i | input | 64 | One-cycle clear pulses, one per device line |
| bus_valid_i | input | 1 | Register access request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 14 | Byte offset from the block base |
| bus_size_i | input | 4 | Access size in bytes |
| bus_wdata_i | input | 64 | Write data |
| bus_rdata_o | output | 64 | Read data, valid with `bus_rvalid_o` |
| bus_rvalid_o | output | 1 | Read response strobe |
| bus_err_o | output | 1 | Sticky illegal-access flag |
| cpu_irq_o | output | 4 | Per-processor device interrupt level |

## Verification
The bench uses the default build: 64 lines and four processors. With this build, line 63 (the top bit) and processor 3 (the last mask) can be exercised. Processor number 4 in the indexed window is then the first out-of-range index. Both address maps and their overlap with the same mask storage can be reached. Each mask uses a different pattern, so a single request change moves the four pending vectors in different ways.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int unsigned ADDR_W     = 14;
    localparam int unsigned SIZE_W     = 4;
    localparam int unsigned WORD_BYTES = 8;

    localparam logic [5:0] PEND_BASE = 6'd8;
    localparam logic [5:0] REQ_REG   = 6'd16;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_PEND,
        SEL_REQ
    } sel_kind_e;

endpackage

// File: rtl/irq_csr_decode.sv
module irq_csr_decode
    import irq_router_pkg::*;
#(
    parameter int unsigned NUM_CPUS = 4,
    parameter int unsigned IDX_W    = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              write_i,
    output sel_kind_e         kind_o,
    output logic [IDX_W-1:0]  cpu_o,
    output logic              legal_o
);

    localparam logic [5:0] NC6 = 6'(NUM_CPUS);

    logic [5:0] regnum;
    logic [5:0] idx6;
    logic       in_range;
    logic       unused_addr_bits;

    assign unused_addr_bits = ^addr_i[3:0];

    always_comb begin
        regnum = addr_i[11:6];
        idx6   = '0;
        kind_o = SEL_NONE;
        if (addr_i[12]) begin
            kind_o = SEL_MASK;
            idx6   = addr_i[9:4];
        end else if (addr_i[13]) begin
            kind_o = SEL_PEND;
            idx6   = addr_i[9:4];
        end else if (regnum < NC6) begin
            kind_o = SEL_MASK;
            idx6   = regnum;
        end else if (regnum >= PEND_BASE && regnum < (PEND_BASE + NC6)) begin
            kind_o = SEL_PEND;
            idx6   = regnum - PEND_BASE;
        end else if (regnum == REQ_REG) begin
            kind_o = SEL_REQ;
        end
        in_range = (idx6 < NC6);
        legal_o  = (size_i == SIZE_W'(WORD_BYTES))
                 && (kind_o != SEL_NONE)
                 && (kind_o == SEL_REQ || in_range)
                 && !(write_i && kind_o != SEL_MASK);
        cpu_o    = idx6[IDX_W-1:0];
    end

endmodule

// File: rtl/irq_req_vec.sv
module irq_req_vec #(
    parameter int unsigned NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] set_i,
    input  logic [NUM_LINES-1:0] clr_i,
    output logic [NUM_LINES-1:0] req_d_o,
    output logic [NUM_LINES-1:0] req_q_o
);

    typedef struct packed {
        logic [NUM_LINES-1:0] req;
    } req_state_t;

    req_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = (st_q.req & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_d_o = st_d.req;
    assign req_q_o = st_q.req;

    // R2
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> (($past(set_i) & ~req_q_o) == '0));

    // R3
    no_new_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0) |=> ((req_q_o & ~$past(req_q_o)) == '0));

endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
    parameter int unsigned NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mask_we_i,
    input  logic [NUM_LINES-1:0] mask_wdata_i,
    input  logic [NUM_LINES-1:0] req_d_i,
    output logic [NUM_LINES-1:0] mask_q_o,
    output logic [NUM_LINES-1:0] pend_q_o,
    output logic                 irq_o
);

    typedef struct packed {
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] pend;
    } slice_state_t;

    slice_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we_i) st_d.mask = mask_wdata_i;
        st_d.pend = st_d.mask & req_d_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_q_o = st_q.mask;
    assign pend_q_o = st_q.pend;
    assign irq_o    = |st_q.pend;

    // R4
    pend_within_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q_o & ~mask_q_o) == '0);

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(mask_we_i || ((req_d_i & mask_q_o) != '0)));

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int unsigned NUM_LINES = 64,
    parameter int unsigned NUM_CPUS  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] dev_set_i,
    input  logic [NUM_LINES-1:0] dev_clr_i,
    input  logic                 bus_valid_i,
    input  logic                 bus_write_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [SIZE_W-1:0]    bus_size_i,
    input  logic [NUM_LINES-1:0] bus_wdata_i,
    output logic [NUM_LINES-1:0] bus_rdata_o,
    output logic                 bus_rvalid_o,
    output logic                 bus_err_o,
    output logic [NUM_CPUS-1:0]  cpu_irq_o
);

    localparam int unsigned IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;

    typedef struct packed {
        logic [NUM_LINES-1:0] rdata;
        logic                 rvalid;
        logic                 err;
    } bus_state_t;

    bus_state_t           st_d, st_q;
    sel_kind_e            kind;
    logic [IDX_W-1:0]     cpu_sel;
    logic                 legal;
    logic [NUM_LINES-1:0] req_d, req_q;
    logic [NUM_LINES-1:0] mask_arr [NUM_CPUS];
    logic [NUM_LINES-1:0] pend_arr [NUM_CPUS];
    logic [NUM_CPUS-1:0]  mask_we;

    irq_csr_decode #(
        .NUM_CPUS (NUM_CPUS),
        .IDX_W    (IDX_W)
    ) u_decode (
        .addr_i  (bus_addr_i),
        .size_i  (bus_size_i),
        .write_i (bus_write_i),
        .kind_o  (kind),
        .cpu_o   (cpu_sel),
        .legal_o (legal)
    );

    irq_req_vec #(
        .NUM_LINES (NUM_LINES)
    ) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (dev_set_i),
        .clr_i   (dev_clr_i),
        .req_d_o (req_d),
        .req_q_o (req_q)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        assign mask_we[c] = bus_valid_i && bus_write_i && legal
                          && (kind == SEL_MASK) && (cpu_sel == IDX_W'(c));

        irq_cpu_slice #(
            .NUM_LINES (NUM_LINES)
        ) u_slice (
            .clk          (clk),
            .rst_n        (rst_n),
            .mask_we_i    (mask_we[c]),
            .mask_wdata_i (bus_wdata_i),
            .req_d_i      (req_d),
            .mask_q_o     (mask_arr[c]),
            .pend_q_o     (pend_arr[c]),
            .irq_o        (cpu_irq_o[c])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = bus_valid_i && !bus_write_i;
        st_d.rdata  = '0;
        if (bus_valid_i && !bus_write_i && legal) begin
            case (kind)
                SEL_MASK: st_d.rdata = mask_arr[cpu_sel];
                SEL_PEND: st_d.rdata = pend_arr[cpu_sel];
                SEL_REQ:  st_d.rdata = req_q;
                default:  st_d.rdata = '0;
            endcase
        end
        st_d.err = st_q.err | (bus_valid_i && !legal);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata_o  = st_q.rdata;
    assign bus_rvalid_o = st_q.rvalid;
    assign bus_err_o    = st_q.err;

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o |=> bus_err_o);

    // R12
    rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid_o |-> $past(bus_valid_i && !bus_write_i));

    // R8
    size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && bus_size_i != SIZE_W'(WORD_BYTES)) |=> bus_err_o);

    // R8
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && !bus_write_i && bus_size_i != SIZE_W'(WORD_BYTES))
        |=> (bus_rdata_o == '0));

endmodule

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;

    localparam int NL = 64;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NL-1:0] dev_set, dev_clr;
    logic          bus_valid, bus_write;
    logic [13:0]   bus_addr;
    logic [3:0]    bus_size;
    logic [NL-1:0] bus_wdata;
    logic [NL-1:0] bus_rdata;
    logic          bus_rvalid, bus_err;
    logic [NC-1:0] cpu_irq;

    always #10 clk = ~clk;

    irq_router #(.NUM_LINES(NL), .NUM_CPUS(NC)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .dev_set_i    (dev_set),
        .dev_clr_i    (dev_clr),
        .bus_valid_i  (bus_valid),
        .bus_write_i  (bus_write),
        .bus_addr_i   (bus_addr),
        .bus_size_i   (bus_size),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .bus_rvalid_o (bus_rvalid),
        .bus_err_o    (bus_err),
        .cpu_irq_o    (cpu_irq)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [NL-1:0] m_mask [NC];
    logic [NL-1:0] m_req;

    logic [NL-1:0] sb_data [$];
    string         sb_tag  [$];

    function automatic logic [13:0] a_mask(int c);  return 14'(c << 6);       endfunction
    function automatic logic [13:0] a_pend(int c);  return 14'((8 + c) << 6); endfunction
    function automatic logic [13:0] a_req();        return 14'(16 << 6);      endfunction
    function automatic logic [13:0] w_mask(int c);  return 14'((1 << 12) | (c << 4)); endfunction
    function automatic logic [13:0] w_pend(int c);  return 14'((1 << 13) | (c << 4)); endfunction

    task automatic check(bit ok, string tag, logic [NL-1:0] act, logic [NL-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: pops one expected item per read response
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (sb_data.size() == 0) begin
                check(1'b0, "R12 unexpected rvalid", {63'd0, bus_rvalid}, '0);
            end else begin
                logic [NL-1:0] e;
                string t;
                e = sb_data.pop_front();
                t = sb_tag.pop_front();
                check(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    task automatic bus_op(bit wr, logic [13:0] addr, logic [3:0] size, logic [NL-1:0] data);
        @(posedge clk); #1;
        bus_valid = 1'b1; bus_write = wr; bus_addr = addr; bus_size = size; bus_wdata = data;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(logic [13:0] addr, logic [NL-1:0] exp, string tag, logic [3:0] size = 4'd8);
        sb_data.push_back(exp);
        sb_tag.push_back(tag);
        bus_op(1'b0, addr, size, '0);
    endtask

    task automatic wr_mask(logic [13:0] addr, int c, logic [NL-1:0] v);
        bus_op(1'b1, addr, 4'd8, v);
        m_mask[c] = v;
    endtask

    task automatic dev(logic [NL-1:0] s, logic [NL-1:0] cl);
        @(posedge clk); #1;
        dev_set = s; dev_clr = cl;
        @(posedge clk); #1;
        dev_set = '0; dev_clr = '0;
        m_req = (m_req & ~cl) | s;
    endtask

    function automatic logic [NC-1:0] exp_irq();
        logic [NC-1:0] r;
        for (int c = 0; c < NC; c++) r[c] = |(m_mask[c] & m_req);
        return r;
    endfunction

    task automatic check_irq(string tag);
        logic [NC-1:0] e;
        e = exp_irq();
        check(cpu_irq === e, tag, NL'(cpu_irq), NL'(e));
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int c = 0; c < NC; c++) m_mask[c] = '0;
        m_req = '0;
    endtask

    task automatic finish_run();
        repeat (3) @(posedge clk);
        check(sb_data.size() == 0, "R12 missing read responses", NL'(sb_data.size()), '0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; dev_set = '0; dev_clr = '0;
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_size = 4'd8; bus_wdata = '0;
        do_reset();

        // R1 reset state
        check(cpu_irq === '0, "R1 irq after reset", NL'(cpu_irq), '0);
        check(bus_err === 1'b0, "R1 err after reset", NL'(bus_err), '0);
        rd(a_mask(3), '0, "R1 mask3 after reset");
        rd(a_pend(0), '0, "R1 pend0 after reset");
        rd(a_req(),   '0, "R1 req after reset");

        // R6 direct map, R7 indexed window writes
        wr_mask(a_mask(0), 0, 64'h8000_0000_0000_0001);
        wr_mask(a_mask(1), 1, '1);
        wr_mask(w_mask(2), 2, 64'h0000_0000_0000_00F0);
        wr_mask(w_mask(3), 3, 64'h0000_0000_0000_0004);
        check_irq("R5 no irq with empty request");
        rd(w_mask(0), m_mask[0], "R7 window read of mask0");
        rd(a_mask(2), m_mask[2], "R6 direct read of mask2");
        rd(a_mask(3), m_mask[3], "R6 direct read of mask3");

        // R2/R4/R5 set line 0
        dev(64'h1, '0);
        check_irq("R5 irq after line0 set");
        rd(a_pend(0), m_mask[0] & m_req, "R4 pend0 after line0");
        rd(a_req(), m_req, "R2 req after line0");

        // lines 63 and 5
        dev(64'h8000_0000_0000_0020, '0);
        check_irq("R5 irq after line63/5 set");
        rd(a_pend(0), m_mask[0] & m_req, "R4 pend0 line63");
        rd(w_pend(2), m_mask[2] & m_req, "R7 window pend2");
        rd(a_pend(3), '0, "R4 pend3 unmatched");

        // R3 spurious clear of line 10
        dev('0, 64'h400);
        check_irq("R3 irq unchanged after spurious clear");
        rd(a_req(), m_req, "R3 req unchanged after spurious clear");
        rd(a_pend(1), m_mask[1] & m_req, "R3 pend1 unchanged");

        // R2 set wins over clear on line 7, line 0 cleared
        dev(64'h80, 64'h81);
        rd(a_req(), m_req, "R2 set wins, line0 cleared");
        check_irq("R5 irq after mixed pulse");

        // R4 mask write recomputes pending
        wr_mask(a_mask(0), 0, '0);
        check_irq("R4 irq0 drops after mask write");
        rd(a_pend(0), '0, "R4 pend0 after mask clear");
        wr_mask(a_mask(3), 3, 64'h80);
        check_irq("R4 irq3 rises after mask write");

        // clear everything
        dev('0, '1);
        check_irq("R5 all irq low after full clear");
        check(bus_err === 1'b0, "R11 no error on legal traffic", NL'(bus_err), '0);

        // R8 bad size read, R11 sticky
        rd(a_mask(1), '0, "R8 narrow read returns zero", 4'd4);
        check(bus_err === 1'b1, "R8 err after narrow read", NL'(bus_err), 64'h1);
        rd(a_mask(1), m_mask[1], "R11 legal read after error");
        check(bus_err === 1'b1, "R11 err stays set", NL'(bus_err), 64'h1);

        // R8 narrow write changes nothing
        bus_op(1'b1, a_mask(1), 4'd2, 64'h5);
        rd(a_mask(1), m_mask[1], "R8 narrow write ignored");

        // R9 write to pending and request
        do_reset();
        wr_mask(a_mask(0), 0, '1);
        dev(64'h8, '0);
        bus_op(1'b1, a_pend(0), 4'd8, '0);
        check(bus_err === 1'b1, "R9 err after pend write", NL'(bus_err), 64'h1);
        rd(a_pend(0), 64'h8, "R9 pend0 unchanged");
        bus_op(1'b1, a_req(), 4'd8, '0);
        rd(a_req(), 64'h8, "R9 req unchanged");
        check_irq("R9 irq unchanged");

        // R10 unmapped number and out-of-range index
        do_reset();
        check(bus_err === 1'b0, "R1 err cleared by reset", NL'(bus_err), '0);
        rd(a_mask(5), '0, "R10 unmapped read returns zero");
        check(bus_err === 1'b1, "R10 err unmapped", NL'(bus_err), 64'h1);
        do_reset();
        rd(w_mask(4), '0, "R10 window index 4 returns zero");
        check(bus_err === 1'b1, "R10 err index 4", NL'(bus_err), 64'h1);

        finish_run();
    end

endmodule